// File: doc/BRIEF.md
# Two-Word Burst Read Controller

This block sits on the reader side of a memory whose ready indication comes from a register. A single start pulse opens a burst of exactly two words. The controller answers ready with a transfer strobe in the same cycle, so that no cycle is lost. The strobe is the AND of the memory's ready with an internal enable flop. A word moves across the data bus on each clock edge at which the strobe is high.

The first word moved goes to one output register and the second word to another. A busy flag covers the burst. A one-cycle done pulse follows the second transfer. After the second word the strobe is withdrawn at once, whatever the memory keeps doing with ready.

Top module: `twoword_reader`

## Requirements
- R1: After synchronous reset, upload, busy and done are 0 and both word outputs are 0.
- R2: upload equals memReady AND busy in the same cycle, with no register in between, and is never high while memReady is low.
- R3: On an edge where upload is low, neither word output changes, and the burst does not advance.
- R4: The data on memData at the first edge with upload high is stored in word0. The data at the second such edge is stored in word1.
- R5: Once the second word has been taken, upload is 0 from the next cycle on, even while memReady stays high. A burst never moves more than two words.
- R6: busy rises on the edge after startReq is seen while idle and falls on the edge that takes the second word. A startReq while busy has no effect on the words or on the burst length.
- R7: done is high for exactly one cycle, the cycle right after the edge that takes the second word.
- R8: With memReady held high from the first busy cycle, the burst takes exactly two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to begin a two-word burst |
| memReady | input | 1 | Registered ready from the memory |
| memData | input | DATA_W | Memory data bus |
| upload | output | 1 | Transfer strobe, combinational |
| word0 | output | DATA_W | First word of the last burst |
| word1 | output | DATA_W | Second word of the last burst |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the second word |

## Verification
The strobe is combinational, so upload is checked within the same cycle in which memReady is driven. Word outputs and busy are registered and are checked one edge after the transfer that moves them. done is checked in that same following cycle and then again one cycle later, when it must be low. The bench drives inputs just after the falling edge and samples a quarter period before the rising edge. It sweeps every 8-bit pattern of ready gaps and predicts which bus values land in which word, and in which cycle busy drops.

// File: rtl/twoword_reader_pkg.sv
package twoword_reader_pkg;
  typedef struct packed {
    logic take0;
    logic take1;
  } rd_strobe_t;
endpackage

// File: rtl/twoword_reader_ctrl.sv
module twoword_reader_ctrl
  import twoword_reader_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       memReady,
  output logic       upload,
  output logic       busy,
  output logic       done,
  output rd_strobe_t strobe
);
  logic enableQ;
  logic wordIdxQ;
  logic doneQ;
  logic accept;

  assign upload = memReady & enableQ;
  assign accept = startReq & ~enableQ;

  always_comb begin
    strobe.take0 = upload & ~wordIdxQ;
    strobe.take1 = upload & wordIdxQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enableQ  <= 1'b0;
      wordIdxQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= strobe.take1;
      if (accept) begin
        enableQ  <= 1'b1;
        wordIdxQ <= 1'b0;
      end else if (strobe.take1) begin
        enableQ  <= 1'b0;
        wordIdxQ <= 1'b0;
      end else if (strobe.take0) begin
        wordIdxQ <= 1'b1;
      end
    end
  end

  assign busy = enableQ;
  assign done = doneQ;
endmodule

// File: rtl/twoword_reader_dp.sv
module twoword_reader_dp
  import twoword_reader_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_strobe_t        strobe,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word0 <= '0;
      word1 <= '0;
    end else begin
      if (strobe.take0) word0 <= memData;
      if (strobe.take1) word1 <= memData;
    end
  end
endmodule

// File: rtl/twoword_reader.sv
module twoword_reader
  import twoword_reader_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memData,
  output logic              upload,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1,
  output logic              busy,
  output logic              done
);
  rd_strobe_t strobe;

  twoword_reader_ctrl u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .memReady(memReady),
    .upload(upload), .busy(busy), .done(done), .strobe(strobe)
  );

  twoword_reader_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .memData(memData),
    .word0(word0), .word1(word1)
  );
endmodule

// File: rtl/twoword_reader_chk.sv
module twoword_reader_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              startReq,
  input logic              memReady,
  input logic [DATA_W-1:0] memData,
  input logic              upload,
  input logic [DATA_W-1:0] word0,
  input logic [DATA_W-1:0] word1,
  input logic              busy,
  input logic              done
);
  logic unusedIn;
  assign unusedIn = startReq ^ (^memData);

  a_r2_upload_needs_ready: assert property (@(posedge clk) disable iff (rst)
    upload |-> memReady);

  a_r3_words_hold: assert property (@(posedge clk) disable iff (rst)
    !upload |=> ($stable(word0) && $stable(word1)));

  a_r5_no_third_word: assert property (@(posedge clk) disable iff (rst)
    done |-> !upload);

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !upload) |=> busy);

  a_r6_busy_falls_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind twoword_reader twoword_reader_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/twoword_reader_bench.sv
module twoword_reader_bench;
  localparam int DATA_W = 8;
  logic clk = 1'b0;
  logic rst, startReq, memReady;
  logic [DATA_W-1:0] memData;
  logic upload, busy, done;
  logic [DATA_W-1:0] word0, word1;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  twoword_reader #(.DATA_W(DATA_W)) u_twoword_reader (
    .clk(clk), .rst(rst), .startReq(startReq), .memReady(memReady),
    .memData(memData), .upload(upload), .word0(word0), .word1(word1),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runBurst(input int p);
    logic [DATA_W-1:0] expW[2];
    int got;
    int cycles;
    @(negedge clk);
    startReq = 1'b1; memReady = 1'b1;
    #2 check("R2 idle", {31'b0, upload}, 0);
    @(negedge clk);
    startReq = 1'b0;
    #1 check("R6 busy rise", {31'b0, busy}, 1);
    got = 0; cycles = 0;
    for (int i = 0; i < 20 && got < 2; i++) begin
      memReady = (i < 8) ? p[i] : 1'b1;
      memData = DATA_W'(p * 17 + i * 3 + 1);
      startReq = (p[0] && i == 1);
      #2;
      check("R2 upload", {31'b0, upload}, {31'b0, memReady});
      check("R6 busy", {31'b0, busy}, 1);
      if (memReady) begin
        expW[got] = memData;
        got++;
      end
      cycles++;
      @(negedge clk);
      startReq = 1'b0;
      #1;
      if (got == 1) check("R4 word0", {24'b0, word0}, {24'b0, expW[0]});
      if (!memReady && got == 0) check("R3 no advance", {31'b0, busy}, 1);
    end
    memReady = 1'b1;
    memData = 8'hA5;
    #1;
    check("R5 upload dropped", {31'b0, upload}, 0);
    check("R7 done", {31'b0, done}, 1);
    check("R6 busy fall", {31'b0, busy}, 0);
    check("R4 word0", {24'b0, word0}, {24'b0, expW[0]});
    check("R4 word1", {24'b0, word1}, {24'b0, expW[1]});
    if (p == 255) check("R8 two cycles", cycles, 2);
    @(negedge clk);
    #2;
    check("R7 done low", {31'b0, done}, 0);
    check("R5 still low", {31'b0, upload}, 0);
    check("R3 words held", {24'b0, word1}, {24'b0, expW[1]});
    memReady = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; startReq = 1'b0; memReady = 1'b0; memData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1 upload", {31'b0, upload}, 0);
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 done", {31'b0, done}, 0);
    check("R1 words", {16'b0, word0, word1}, 0);
    memReady = 1'b1;
    #1 check("R2 no busy", {31'b0, upload}, 0);
    memReady = 1'b0;
    for (int p = 0; p < 256; p++) runBurst(p);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule